// File: doc/BRIEF.md
# Vertex Attribute Fetch Address Generator

This block turns one vertex's attribute layout into a stream of memory read requests. A 64-bit layout word describes up to twelve attributes, each with a 2-bit element type and a 2-bit component count. It also carries a 12-bit default mask and a 4-bit count of the attributes in use. Each attribute has its own 29-bit base address, and the vertex number picks the record inside each attribute's array.

On a start pulse the block captures the layout word, the vertex number and the base addresses. It then walks the attributes from the lowest index upward, and the components of each attribute in ascending order. For every component of a fetched attribute it issues one request carrying the attribute index, the component index, the byte address and the element type. An attribute that is flagged as default, or whose index is 12 or higher, is not read from memory. It gives a single indication instead, telling the consumer to take the value from its default table. Requests leave through a valid/ready handshake, one per cycle at most, and a one-cycle done pulse closes the vertex. Memory access and numeric conversion are left to the consumer.

Top module: `attr_fetch_agen`

## Requirements
- R1: After reset, and whenever no vertex is in progress, `req_valid_o`, `done_o` and `busy_o` are 0.
- R2: For attribute n below 12, layout bits [4n+1:4n] give the element type (0 signed byte, 1 unsigned byte, 2 signed 16-bit, 3 32-bit float), which is reported on `req_fmt_o`. Bits [4n+3:4n+2] plus one give the number of component requests issued for that attribute.
- R3: A component request's address is the attribute base, plus the vertex number times the attribute stride, plus the component index times the element size. The element size is 4 bytes for float, 2 bytes for 16-bit and 1 byte for either byte type.
- R4: The attribute stride is the component count times the element size, so the same layout gives addresses that step by that stride per vertex number.
- R5: Requests appear in ascending attribute order, and within an attribute in ascending component order starting at 0.
- R6: If layout bit 48+n is set, attribute n produces exactly one request with `req_dflt_o`=1, component 0, address 0 and type 0. It produces no fetch requests.
- R7: Every attribute with index 12 or higher is treated as default, whatever the mask holds.
- R8: The number of attributes walked is layout bits [63:60] plus one.
- R9: While `req_valid_o` is 1 and `req_ready_i` is 0, the request stays valid and its fields stay unchanged in the next cycle.
- R10: `done_o` is high for exactly one cycle, the cycle after the last request is accepted. `busy_o` stays high from the cycle after the start until that done cycle.
- R11: While a vertex is in progress, `start_i` is ignored. Changes on `desc_i`, `vertex_i` or `base_i` do not affect the requests, because these inputs are captured when the start is taken.
- R12: Base addresses are 29 bits wide and are zero-extended. The address is a 32-bit sum, so a carry above bit 28 appears in the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin walking one vertex (taken only when idle) |
| desc_i | input | 64 | Packed attribute layout word |
| vertex_i | input | 16 | Vertex number |
| base_i | input | 464 | Sixteen 29-bit base addresses, attribute n at bits [29n+28:29n] |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Consumer accepts the request this cycle |
| req_attr_o | output | 4 | Attribute index of the request |
| req_comp_o | output | 2 | Component index of the request |
| req_dflt_o | output | 1 | 1: take the default value, no memory read |
| req_fmt_o | output | 2 | Element type of the request |
| req_addr_o | output | 32 | Byte read address |
| busy_o | output | 1 | A vertex is being walked |
| done_o | output | 1 | One-cycle pulse after the last request |

## Verification
The walk is driven with five layouts. One mixes all four element types with different counts over four attributes, which separates element size from stride. One has sixteen attributes with two masked ones and a stalling consumer, which exposes mask decoding and request holding. One uses a single one-component attribute at vertex 0, the shortest possible walk. One flags every attribute default and runs past index 12, so the mask is told apart from the index rule. One has a base near the top of the 29-bit range with the largest vertex number, which shows whether the sum carries into bits above 28. A start pulse with a changed layout partway through one walk, and a reset in the middle of a walk, test that the captured job is kept and that reset clears everything.

// File: rtl/attr_fetch_pkg.sv
package attr_fetch_pkg;

  // Layout word geometry
  localparam int DESC_W        = 64;
  localparam int FMT_W         = 2;
  localparam int CNT_W         = 2;
  localparam int SLOT_W        = FMT_W + CNT_W;
  localparam int NUM_DESC_ATTR = 12;
  localparam int MASK_LSB      = NUM_DESC_ATTR * SLOT_W;
  localparam int TOTAL_W       = 4;
  localparam int TOTAL_LSB     = MASK_LSB + NUM_DESC_ATTR;
  localparam int NUM_ATTR      = 1 << TOTAL_W;
  localparam int ATTR_W        = TOTAL_W;
  localparam int COMP_W        = CNT_W;

  // Address geometry
  localparam int BASE_W  = 29;
  localparam int ADDR_W  = 32;
  localparam int VTX_W   = 16;
  localparam int ESIZE_W = 3;
  localparam int STRD_W  = 5;

  typedef enum logic [FMT_W-1:0] {
    ELEM_S8  = 2'd0,
    ELEM_U8  = 2'd1,
    ELEM_S16 = 2'd2,
    ELEM_F32 = 2'd3
  } elem_fmt_e;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RUN  = 2'd1,
    WALK_DONE = 2'd2
  } walk_state_e;

  // Bytes per element for a type code
  function automatic logic [ESIZE_W-1:0] elem_bytes(logic [FMT_W-1:0] f);
    case (elem_fmt_e'(f))
      ELEM_F32: return ESIZE_W'(4);
      ELEM_S16: return ESIZE_W'(2);
      default:  return ESIZE_W'(1);
    endcase
  endfunction

  // Bytes per vertex record of one attribute
  function automatic logic [STRD_W-1:0] attr_stride(logic [FMT_W-1:0] f,
                                                   logic [CNT_W-1:0] cnt_m1);
    logic [STRD_W-1:0] n;
    n = STRD_W'(cnt_m1) + STRD_W'(1);
    return STRD_W'(n * STRD_W'(elem_bytes(f)));
  endfunction

  // Byte address of one component
  function automatic logic [ADDR_W-1:0] comp_address(logic [BASE_W-1:0]  base,
                                                     logic [VTX_W-1:0]   vtx,
                                                     logic [STRD_W-1:0]  stride,
                                                     logic [COMP_W-1:0]  comp,
                                                     logic [ESIZE_W-1:0] esz);
    logic [ADDR_W-1:0] rec_off;
    logic [ADDR_W-1:0] comp_off;
    rec_off  = ADDR_W'(vtx) * ADDR_W'(stride);
    comp_off = ADDR_W'(comp) * ADDR_W'(esz);
    return ADDR_W'(base) + rec_off + comp_off;
  endfunction

endpackage

// File: rtl/attr_desc_decode.sv
module attr_desc_decode
  import attr_fetch_pkg::*;
#(
  parameter int N_ATTR   = NUM_ATTR,
  parameter int N_DESC   = NUM_DESC_ATTR,
  localparam int TOT_W   = $clog2(N_ATTR) + 1
) (
  input  logic [DESC_W-1:0]             desc,
  output logic [N_ATTR-1:0][FMT_W-1:0]  fmt,
  output logic [N_ATTR-1:0][CNT_W-1:0]  cnt_m1,
  output logic [N_ATTR-1:0]             dflt,
  output logic [TOT_W-1:0]              total
);

  // Per-slot field extraction; slots past the layout word are forced default
  for (genvar n = 0; n < N_ATTR; n++) begin : g_slot
    if (n < N_DESC) begin : g_coded
      assign fmt[n]    = desc[n*SLOT_W +: FMT_W];
      assign cnt_m1[n] = desc[n*SLOT_W + FMT_W +: CNT_W];
      assign dflt[n]   = desc[MASK_LSB + n];
    end else begin : g_fixed
      assign fmt[n]    = '0;
      assign cnt_m1[n] = '0;
      assign dflt[n]   = 1'b1;
    end
  end

  assign total = TOT_W'(desc[TOTAL_LSB +: TOTAL_W]) + TOT_W'(1);

endmodule

// File: rtl/attr_walk_ctrl.sv
module attr_walk_ctrl
  import attr_fetch_pkg::*;
#(
  parameter int N_ATTR  = NUM_ATTR,
  localparam int AW     = $clog2(N_ATTR),
  localparam int TOT_W  = AW + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          ready,
  input  logic [N_ATTR-1:0][CNT_W-1:0]  cnt_m1,
  input  logic [N_ATTR-1:0]             dflt,
  input  logic [TOT_W-1:0]              total,
  output logic                          launch,
  output logic                          valid,
  output logic [AW-1:0]                 attr,
  output logic [COMP_W-1:0]             comp,
  output logic                          busy,
  output logic                          done
);

  walk_state_e       state_q;
  logic [AW-1:0]     attr_q;
  logic [COMP_W-1:0] comp_q;

  // Named events for the assertions
  logic accept_w;
  logic last_comp_w;
  logic last_attr_w;
  logic finish_w;

  assign launch      = (state_q == WALK_IDLE) && start;
  assign accept_w    = valid && ready;
  assign last_comp_w = dflt[attr_q] || (comp_q == cnt_m1[attr_q]);
  assign last_attr_w = (TOT_W'(attr_q) + TOT_W'(1)) == total;
  assign finish_w    = accept_w && last_comp_w && last_attr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      attr_q  <= '0;
      comp_q  <= '0;
    end else begin
      case (state_q)
        WALK_IDLE: begin
          if (launch) begin
            state_q <= WALK_RUN;
            attr_q  <= '0;
            comp_q  <= '0;
          end
        end
        WALK_RUN: begin
          if (accept_w) begin
            if (!last_comp_w) begin
              comp_q <= comp_q + COMP_W'(1);
            end else if (last_attr_w) begin
              state_q <= WALK_DONE;
            end else begin
              attr_q <= attr_q + AW'(1);
              comp_q <= '0;
            end
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign valid = (state_q == WALK_RUN);
  assign busy  = (state_q != WALK_IDLE);
  assign done  = (state_q == WALK_DONE);
  assign attr  = attr_q;
  assign comp  = comp_q;

  // R1: nothing is offered while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!valid && !done));

  // R5: after an accepted non-final request the next one moves forward
  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !finish_w) |=>
      (valid && ((attr == $past(attr) && comp == $past(comp) + COMP_W'(1)) ||
                 (attr == $past(attr) + AW'(1) && comp == '0))));

  // R10: done is a single pulse that follows the final acceptance
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    finish_w |=> (done && !valid));

  // R11: a start during a walk does not restart the walk
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && start && !accept_w) |=> (valid && $stable(attr) && $stable(comp)));

endmodule

// File: rtl/attr_addr_calc.sv
module attr_addr_calc
  import attr_fetch_pkg::*;
(
  input  logic [BASE_W-1:0] base,
  input  logic [VTX_W-1:0]  vtx,
  input  logic [FMT_W-1:0]  fmt,
  input  logic [CNT_W-1:0]  cnt_m1,
  input  logic [COMP_W-1:0] comp,
  input  logic              dflt,
  output logic [ADDR_W-1:0] addr,
  output logic [FMT_W-1:0]  fmt_out
);

  logic [ESIZE_W-1:0] esize_w;
  logic [STRD_W-1:0]  stride_w;
  logic [ADDR_W-1:0]  fetch_addr_w;

  assign esize_w      = elem_bytes(fmt);
  assign stride_w     = attr_stride(fmt, cnt_m1);
  assign fetch_addr_w = comp_address(base, vtx, stride_w, comp, esize_w);

  // Default attributes carry no address and no type
  assign addr    = dflt ? '0 : fetch_addr_w;
  assign fmt_out = dflt ? '0 : fmt;

endmodule

// File: rtl/attr_fetch_agen.sv
module attr_fetch_agen
  import attr_fetch_pkg::*;
#(
  parameter int N_ATTR = NUM_ATTR,
  localparam int AW    = $clog2(N_ATTR),
  localparam int TOT_W = AW + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [DESC_W-1:0]          desc_i,
  input  logic [VTX_W-1:0]           vertex_i,
  input  logic [N_ATTR*BASE_W-1:0]   base_i,
  output logic                       req_valid_o,
  input  logic                       req_ready_i,
  output logic [AW-1:0]              req_attr_o,
  output logic [COMP_W-1:0]          req_comp_o,
  output logic                       req_dflt_o,
  output logic [FMT_W-1:0]           req_fmt_o,
  output logic [ADDR_W-1:0]          req_addr_o,
  output logic                       busy_o,
  output logic                       done_o
);

  // Captured job
  logic [DESC_W-1:0]              desc_q;
  logic [VTX_W-1:0]               vtx_q;
  logic [N_ATTR-1:0][BASE_W-1:0]  base_q;

  logic                           launch_w;
  logic [N_ATTR-1:0][FMT_W-1:0]   fmt_w;
  logic [N_ATTR-1:0][CNT_W-1:0]   cnt_w;
  logic [N_ATTR-1:0]              dflt_w;
  logic [TOT_W-1:0]               total_w;
  logic [AW-1:0]                  attr_w;
  logic [COMP_W-1:0]              comp_w;
  logic                           valid_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q <= '0;
      vtx_q  <= '0;
      base_q <= '0;
    end else if (launch_w) begin
      desc_q <= desc_i;
      vtx_q  <= vertex_i;
      base_q <= base_i;
    end
  end

  attr_desc_decode #(.N_ATTR(N_ATTR), .N_DESC(NUM_DESC_ATTR)) u_decode (
    .desc   (desc_q),
    .fmt    (fmt_w),
    .cnt_m1 (cnt_w),
    .dflt   (dflt_w),
    .total  (total_w)
  );

  attr_walk_ctrl #(.N_ATTR(N_ATTR)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .ready  (req_ready_i),
    .cnt_m1 (cnt_w),
    .dflt   (dflt_w),
    .total  (total_w),
    .launch (launch_w),
    .valid  (valid_w),
    .attr   (attr_w),
    .comp   (comp_w),
    .busy   (busy_o),
    .done   (done_o)
  );

  attr_addr_calc u_agu (
    .base    (base_q[attr_w]),
    .vtx     (vtx_q),
    .fmt     (fmt_w[attr_w]),
    .cnt_m1  (cnt_w[attr_w]),
    .comp    (comp_w),
    .dflt    (dflt_w[attr_w]),
    .addr    (req_addr_o),
    .fmt_out (req_fmt_o)
  );

  assign req_valid_o = valid_w;
  assign req_attr_o  = attr_w;
  assign req_comp_o  = comp_w;
  assign req_dflt_o  = dflt_w[attr_w];

  // R9: a stalled request is held unchanged
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_attr_o) && $stable(req_comp_o) &&
       $stable(req_addr_o) && $stable(req_dflt_o) && $stable(req_fmt_o)));

  // R6: a default indication names component 0 and carries no address or type
  assert_default_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_dflt_o) |-> (req_comp_o == '0 && req_addr_o == '0 && req_fmt_o == '0));

  // R7: high attribute indices never fetch
  assert_high_index_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_attr_o >= AW'(NUM_DESC_ATTR)) |-> req_dflt_o);

  // R10: busy holds from the cycle after the start until done
  assert_busy_span_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/test_attr_fetch_agen.sv
module test_attr_fetch_agen;
  import attr_fetch_pkg::*;

  localparam int NA = NUM_ATTR;

  typedef struct packed {
    logic [63:0] desc;
    logic [15:0] vtx;
    logic [31:0] seed;
    logic        stall;
    logic        poke;
    logic        hi_base;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{64'h3000_0000_0000_294F, 16'd5,      32'h0000_1000, 1'b0, 1'b0, 1'b0},
    '{64'hF012_6666_6666_6666, 16'd3,      32'h0040_0000, 1'b1, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0001, 16'd0,      32'h0000_0200, 1'b0, 1'b0, 1'b0},
    '{64'hCFFF_0000_0000_0000, 16'd7,      32'h0000_0300, 1'b1, 1'b0, 1'b0},
    '{64'h1000_0000_0000_003C, 16'hFFFF,   32'h1FFF_FF00, 1'b0, 1'b0, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [63:0]       desc_i = '0;
  logic [15:0]       vertex_i = '0;
  logic [NA-1:0][28:0] bases = '0;
  logic              req_ready_i = 1'b0;
  logic              req_valid_o;
  logic [3:0]        req_attr_o;
  logic [1:0]        req_comp_o;
  logic              req_dflt_o;
  logic [1:0]        req_fmt_o;
  logic [31:0]       req_addr_o;
  logic              busy_o;
  logic              done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Expected request stream
  logic [3:0]  e_attr [64];
  logic [1:0]  e_comp [64];
  logic        e_dflt [64];
  logic [1:0]  e_fmt  [64];
  logic [31:0] e_addr [64];
  int          e_n;

  always #2 clk = ~clk;

  attr_fetch_agen i_attr_fetch_agen (
    .clk, .rst_n, .start_i, .desc_i, .vertex_i,
    .base_i (bases),
    .req_valid_o, .req_ready_i, .req_attr_o, .req_comp_o, .req_dflt_o,
    .req_fmt_o, .req_addr_o, .busy_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench's own model of the walk
  task automatic build_expect(input logic [63:0] d, input logic [15:0] v);
    int total;
    e_n = 0;
    total = int'(d[63:60]) + 1;
    for (int a = 0; a < total; a++) begin
      bit is_def;
      is_def = (a >= 12) ? 1'b1 : d[48 + a];
      if (is_def) begin
        e_attr[e_n] = 4'(a); e_comp[e_n] = 0; e_dflt[e_n] = 1;
        e_fmt[e_n] = 0; e_addr[e_n] = 0; e_n++;
      end else begin
        int t, cnt, sz;
        t   = int'(d[4*a +: 2]);
        cnt = int'(d[4*a + 2 +: 2]) + 1;
        sz  = (t == 3) ? 4 : ((t == 2) ? 2 : 1);
        for (int c = 0; c < cnt; c++) begin
          e_attr[e_n] = 4'(a); e_comp[e_n] = 2'(c); e_dflt[e_n] = 0;
          e_fmt[e_n] = 2'(t);
          e_addr[e_n] = {3'b000, bases[a]} + 32'(v) * 32'(cnt * sz) + 32'(c * sz);
          e_n++;
        end
      end
    end
  endtask

  task automatic run_vec(input vec_t vv);
    int idx, cyc;
    bit held;
    logic [3:0] h_attr; logic [1:0] h_comp; logic [31:0] h_addr;
    logic [63:0] d_run;
    d_run = vv.desc;
    for (int i = 0; i < NA; i++) bases[i] = 29'(vv.seed + 32'(i) * 32'h0123_4567);
    if (vv.hi_base) bases[0] = 29'h1FFF_FF00;
    desc_i = vv.desc; vertex_i = vv.vtx;
    build_expect(vv.desc, vv.vtx);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after start", 64'(busy_o), 64'd1);
    idx = 0; cyc = 0; held = 0;
    h_attr = '0; h_comp = '0; h_addr = '0;
    while (idx < e_n && cyc < 400) begin
      req_ready_i = !(vv.stall && (cyc % 3 == 1));
      if (vv.poke && cyc == 2) begin
        start_i = 1'b1; desc_i = 64'h0000_0000_0000_0001; vertex_i = 16'h0;
        bases = '0;
      end else begin
        start_i = 1'b0;
      end
      if (held) begin
        chk(req_valid_o && req_attr_o == h_attr && req_comp_o == h_comp &&
            req_addr_o == h_addr, "R9", "held request",
            {28'(0), req_attr_o, req_addr_o}, {28'(0), h_attr, h_addr});
        held = 0;
      end
      chk(!done_o, "R10", "done during walk", 64'(done_o), 64'd0);
      if (req_valid_o && !req_ready_i) begin
        held = 1; h_attr = req_attr_o; h_comp = req_comp_o; h_addr = req_addr_o;
      end
      if (req_valid_o && req_ready_i) begin
        chk(req_attr_o == e_attr[idx] && req_comp_o == e_comp[idx],
            vv.poke ? "R11" : "R5", "attr/comp order",
            64'({req_attr_o, req_comp_o}), 64'({e_attr[idx], e_comp[idx]}));
        chk(req_dflt_o == e_dflt[idx], (e_attr[idx] >= 12) ? "R7" : "R6",
            "default flag", 64'(req_dflt_o), 64'(e_dflt[idx]));
        chk(req_fmt_o == e_fmt[idx], "R2", "type field", 64'(req_fmt_o), 64'(e_fmt[idx]));
        chk(req_addr_o == e_addr[idx],
            vv.hi_base ? "R12" : (e_dflt[idx] ? "R6" : (vv.vtx != 0 ? "R4" : "R3")),
            "address", 64'(req_addr_o), 64'(e_addr[idx]));
        idx++;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(idx == e_n, "R8", "request count", 64'(idx), 64'(e_n));
    chk(done_o == 1'b1 && !req_valid_o, "R10", "done after last",
        64'({done_o, req_valid_o}), 64'b10);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R10", "done single pulse",
        64'({done_o, busy_o}), 64'b00);
    req_ready_i = 1'b0;
    desc_i = d_run;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid_o && !done_o && !busy_o, "R1", "in reset",
        64'({req_valid_o, done_o, busy_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid_o && !done_o && !busy_o, "R1", "after reset",
        64'({req_valid_o, done_o, busy_o}), 64'd0);

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

    // Idle with ready high: still nothing offered
    req_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(!req_valid_o && !busy_o, "R1", "idle stays quiet",
        64'({req_valid_o, busy_o}), 64'd0);

    // Reset in the middle of a walk
    req_ready_i = 1'b0;
    desc_i = VECS[1].desc;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk(!req_valid_o && !busy_o && !done_o, "R1", "reset mid-walk",
        64'({req_valid_o, busy_o, done_o}), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid_o && !busy_o, "R1", "quiet after mid-walk reset",
        64'({req_valid_o, busy_o}), 64'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: run did not end actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule